// File: doc/BRIEF.md
# Packed Dot-Product Accumulate Unit

This unit accumulates short integer dot products into a 256-bit accumulator vector. The accumulator and both operands are divided into eight 32-bit lanes. Each lane forms a short dot product from sub-elements of its two operand lanes and adds that sum to its accumulator lane. Two element formats are available:

- **Byte mode:** four products of an unsigned byte and a signed byte.
- **Word mode:** two products of a signed 16-bit word and a signed 16-bit word.

The accumulation can wrap modulo 2^32, or it can clamp to the signed 32-bit range.

An 8-bit lane mask chooses, per lane, between the computed result and a fallback value. The fallback is either the accumulator lane unchanged (merge) or zero. A build parameter limits the unit to its low four lanes. In that form the upper half of the result is always zero.

The result is captured in a single output register. That register loads only when the input valid is high, and the output valid is a one-cycle-delayed copy of the input valid.

Top module: `dot_acc_unit`

## Requirements
- R1: With `word_mode`=0, result lane j (bits 32j+31..32j) is the accumulator lane plus four products. Each product multiplies byte k of the A lane (bits 32j+8k+7..32j+8k), read as unsigned 0..255, by byte k of the B lane, read as signed. For example, 255 × -128 contributes -32640.
- R2: With `word_mode`=1, result lane j is the accumulator lane plus two products. Each product multiplies a signed 16-bit word of the A lane by the signed 16-bit word at the same position in the B lane, with the low half at bits 32j+15..32j.
- R3: With `sat_en`=0, the lane sum wraps modulo 2^32. For example, two products of -32768 × -32768 added to S give 0x80000000 + S.
- R4: With `sat_en`=1, the complete sum of the accumulator and all products is clamped. A sum above 2^31-1 gives 0x7FFFFFFF, and a sum below -2^31 gives 0x80000000.
- R5: When `lane_mask` bit j is 1, lane j carries the computed value.
- R6: When `lane_mask` bit j is 0 and `zero_mask`=0, lane j equals accumulator lane j unchanged.
- R7: When `lane_mask` bit j is 0 and `zero_mask`=1, lane j is zero.
- R8: With `WIDE_FORM`=0, only lanes 0..3 are computed, result bits 255..128 are always zero, and mask bits 7..4 have no effect.
- R9: `out_valid` and a new `result` appear on the clock edge after the one that samples `in_valid`=1. While `in_valid` is 0, `result` holds its value.
- R10: While reset is asserted, `out_valid` is 0 and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | Operands valid; loads the output register |
| word_mode | input | 1 | 0: unsigned × signed byte quads; 1: signed word pairs |
| sat_en | input | 1 | 1: signed 32-bit saturation; 0: wrap |
| zero_mask | input | 1 | 1: masked lanes output zero; 0: masked lanes pass the accumulator |
| lane_mask | input | 8 | Per-lane enable, bit j for lane j |
| acc_in | input | 256 | Accumulator vector S |
| opa | input | 256 | Operand A (unsigned bytes or signed words) |
| opb | input | 256 | Operand B (signed bytes or signed words) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 256 | Registered result vector |

## Verification
The unit has only one register stage and no feedback path. A wrong lane value, a wrong clamp choice or a wrong mask fallback therefore appears on `result` in the cycle right after the offending input, and is confined to the affected lane. A fault in the narrow form shows up as non-zero upper bits. A fault in the load enable shows up as `result` changing while no input is valid, or as `out_valid` losing its alignment with the new data. The corner values to watch are the zero-extension of byte 255, the word product that wraps to 0x80000000, and sums that cross either 32-bit bound.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int LANE_W    = 32;
  localparam int MAX_LANES = 8;
  localparam int VEC_W     = LANE_W * MAX_LANES;
  localparam int BYTES_PER = LANE_W / 8;
  localparam int WORDS_PER = LANE_W / 16;
  // Wide enough for the accumulator plus all products without overflow.
  localparam int SUM_W     = LANE_W + 3;
  localparam logic [LANE_W-1:0] SAT_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SAT_MIN = {1'b1, {(LANE_W-1){1'b0}}};
endpackage

// File: rtl/dpa_clamp.sv
module dpa_clamp
  import dpa_pkg::*;
(
  input  logic [SUM_W-1:0]  sum,
  input  logic              sat_en,
  output logic [LANE_W-1:0] y
);
  logic [SUM_W-LANE_W:0] top_bits;
  logic                  out_of_range;

  always_comb begin
    top_bits     = sum[SUM_W-1:LANE_W-1];
    out_of_range = !((&top_bits) || !(|top_bits));
    if (sat_en && out_of_range) y = sum[SUM_W-1] ? SAT_MIN : SAT_MAX;
    else                        y = sum[LANE_W-1:0];
  end
endmodule

// File: rtl/dpa_lane.sv
module dpa_lane
  import dpa_pkg::*;
(
  input  logic [LANE_W-1:0] acc,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              word_mode,
  input  logic              sat_en,
  output logic [LANE_W-1:0] res
);
  logic signed [16:0] bprod [BYTES_PER];
  logic signed [31:0] wprod [WORDS_PER];
  logic [SUM_W-1:0]   acc_x;
  logic [SUM_W-1:0]   sum;

  for (genvar k = 0; k < BYTES_PER; k++) begin : g_byte
    assign bprod[k] = $signed({1'b0, a[8*k +: 8]}) * $signed(b[8*k +: 8]);
  end
  for (genvar k = 0; k < WORDS_PER; k++) begin : g_word
    assign wprod[k] = $signed(a[16*k +: 16]) * $signed(b[16*k +: 16]);
  end

  always_comb begin
    acc_x = {{(SUM_W-LANE_W){acc[LANE_W-1]}}, acc};
    sum   = acc_x;
    if (word_mode) begin
      for (int k = 0; k < WORDS_PER; k++)
        sum = sum + {{(SUM_W-32){wprod[k][31]}}, wprod[k]};
    end else begin
      for (int k = 0; k < BYTES_PER; k++)
        sum = sum + {{(SUM_W-17){bprod[k][16]}}, bprod[k]};
    end
  end

  dpa_clamp u_clamp (
    .sum    (sum),
    .sat_en (sat_en),
    .y      (res)
  );
endmodule

// File: rtl/dot_acc_unit.sv
module dot_acc_unit
  import dpa_pkg::*;
#(
  parameter bit WIDE_FORM = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 word_mode,
  input  logic                 sat_en,
  input  logic                 zero_mask,
  input  logic [MAX_LANES-1:0] lane_mask,
  input  logic [VEC_W-1:0]     acc_in,
  input  logic [VEC_W-1:0]     opa,
  input  logic [VEC_W-1:0]     opb,
  output logic                 out_valid,
  output logic [VEC_W-1:0]     result
);
  localparam int ACT_LANES = WIDE_FORM ? MAX_LANES : MAX_LANES / 2;
  localparam int ACT_W     = ACT_LANES * LANE_W;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [VEC_W-1:0] res_d;
  logic [VEC_W-1:0] res_q;
  logic             vld_q;
  logic             res_en;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    if (j < ACT_LANES) begin : g_on
      logic [LANE_W-1:0] lane_val;
      dpa_lane u_lane (
        .acc       (acc_in[LANE_W*j +: LANE_W]),
        .a         (opa[LANE_W*j +: LANE_W]),
        .b         (opb[LANE_W*j +: LANE_W]),
        .word_mode (word_mode),
        .sat_en    (sat_en),
        .res       (lane_val)
      );
      always_comb begin
        if (lane_mask[j])   res_d[LANE_W*j +: LANE_W] = lane_val;
        else if (zero_mask) res_d[LANE_W*j +: LANE_W] = '0;
        else                res_d[LANE_W*j +: LANE_W] = acc_in[LANE_W*j +: LANE_W];
      end
    end else begin : g_off
      assign res_d[LANE_W*j +: LANE_W] = '0;
    end
  end

  assign res_en = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (!rst_s) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (res_en) res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  // R9: valid tracks the input one cycle later.
  p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_s)
    in_valid |=> out_valid);
  // R9: no load without valid input.
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_s)
    !in_valid |=> $stable(result));
  // R6: masked lane 0 with merge passes the accumulator.
  p_merge_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && !zero_mask && !lane_mask[0]) |=> result[LANE_W-1:0] == $past(acc_in[LANE_W-1:0]));
  // R7: masked lane 0 with zeroing gives zero.
  p_zero_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && zero_mask && !lane_mask[0]) |=> result[LANE_W-1:0] == '0);
  // R8: narrow form keeps upper lanes clear.
  if (ACT_LANES < MAX_LANES) begin : g_chk_narrow
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_s)
      in_valid |=> result[VEC_W-1:ACT_W] == '0);
  end
endmodule

// File: tb/dot_acc_unit_test.sv
module dot_acc_unit_test;
  localparam int VW = 256;

  typedef struct packed {
    logic        wm;
    logic        sat;
    logic        zm;
    logic [7:0]  mask;
    logic [31:0] s;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam vec_t TV [0:7] = '{
    '{1'b0, 1'b0, 1'b0, 8'hFF, 32'h00001000, 32'h01020304, 32'h05FA07F8},
    '{1'b0, 1'b1, 1'b0, 8'hA5, 32'h7FFFFF00, 32'hFFFFFFFF, 32'h7F7F7F7F},
    '{1'b1, 1'b0, 1'b0, 8'hFF, 32'h12345678, 32'h7FFF8001, 32'h7FFF7FFF},
    '{1'b1, 1'b1, 1'b1, 8'h3C, 32'h80000010, 32'h7FFF7FFF, 32'h80018001},
    '{1'b0, 1'b0, 1'b1, 8'h0F, 32'hDEADBEEF, 32'h80FF0180, 32'h807F80FF},
    '{1'b1, 1'b0, 1'b1, 8'hF0, 32'h00000000, 32'h80008000, 32'h80008000},
    '{1'b0, 1'b1, 1'b1, 8'h00, 32'h0BADF00D, 32'h11223344, 32'h55667788},
    '{1'b1, 1'b1, 1'b0, 8'h5A, 32'hFFFFFFF0, 32'h00030004, 32'hFFFEFFFD}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, word_mode, sat_en, zero_mask;
  logic [7:0]    lane_mask;
  logic [VW-1:0] acc_in, opa, opb;
  logic          out_valid, out_valid_n;
  logic [VW-1:0] result, result_n;
  int            errors = 0;
  int            checks = 0;

  always #5 clk = ~clk;

  dot_acc_unit #(.WIDE_FORM(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .word_mode(word_mode),
    .sat_en(sat_en), .zero_mask(zero_mask), .lane_mask(lane_mask),
    .acc_in(acc_in), .opa(opa), .opb(opb), .out_valid(out_valid), .result(result));

  dot_acc_unit #(.WIDE_FORM(1'b0)) uut_n (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .word_mode(word_mode),
    .sat_en(sat_en), .zero_mask(zero_mask), .lane_mask(lane_mask),
    .acc_in(acc_in), .opa(opa), .opb(opb), .out_valid(out_valid_n), .result(result_n));

  function automatic logic [31:0] m_lane(logic wm, logic sat, logic [31:0] s, logic [31:0] a, logic [31:0] b);
    longint t;
    t = longint'($signed(s));
    if (wm) begin
      for (int k = 0; k < 2; k++)
        t += longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
    end else begin
      for (int k = 0; k < 4; k++)
        t += longint'(a[8*k +: 8]) * longint'($signed(b[8*k +: 8]));
    end
    if (sat && t > 64'sd2147483647)  t = 64'sd2147483647;
    if (sat && t < -64'sd2147483648) t = -64'sd2147483648;
    return t[31:0];
  endfunction

  function automatic logic [VW-1:0] m_vec(logic wm, logic sat, logic zm, logic [7:0] mask,
                                          logic [VW-1:0] s, logic [VW-1:0] a, logic [VW-1:0] b, int act);
    logic [VW-1:0] r;
    r = '0;
    for (int j = 0; j < act; j++) begin
      if (mask[j])  r[32*j +: 32] = m_lane(wm, sat, s[32*j +: 32], a[32*j +: 32], b[32*j +: 32]);
      else if (zm)  r[32*j +: 32] = 32'h0;
      else          r[32*j +: 32] = s[32*j +: 32];
    end
    return r;
  endfunction

  task automatic chk(logic ok, string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, sample at the next falling edge.
  task automatic run(logic wm, logic sat, logic zm, logic [7:0] mask,
                     logic [VW-1:0] s, logic [VW-1:0] a, logic [VW-1:0] b);
    @(negedge clk);
    word_mode = wm; sat_en = sat; zero_mask = zm; lane_mask = mask;
    acc_in = s; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [VW-1:0] s, a, b, exp, held;
    rst_n = 1'b0; in_valid = 1'b0; word_mode = 1'b0; sat_en = 1'b0;
    zero_mask = 1'b0; lane_mask = '0; acc_in = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0 && result == '0, "R10 reset", {255'd0, out_valid} | result, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R10 idle after reset", {255'd0, out_valid}, '0);

    // Table walk: each vector against both forms.
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        s[32*j +: 32] = TV[i].s ^ (32'(j) << 4);
        a[32*j +: 32] = TV[i].a;
        b[32*j +: 32] = TV[i].b ^ {4{8'(j)}};
      end
      run(TV[i].wm, TV[i].sat, TV[i].zm, TV[i].mask, s, a, b);
      exp = m_vec(TV[i].wm, TV[i].sat, TV[i].zm, TV[i].mask, s, a, b, 8);
      chk(result == exp, TV[i].wm ? "R2 R5 word table" : "R1 R5 byte table", result, exp);
      chk(out_valid == 1'b1, "R9 valid after load", {255'd0, out_valid}, 1);
      exp = m_vec(TV[i].wm, TV[i].sat, TV[i].zm, TV[i].mask, s, a, b, 4);
      chk(result_n == exp, "R8 narrow table", result_n, exp);
    end

    // R1: zero-extended 255 times -128
    run(1'b0, 1'b0, 1'b0, 8'h01, '0, 256'h000000FF, 256'h00000080);
    chk(result[31:0] == 32'hFFFF8080, "R1 255x-128", result, 256'hFFFF8080);
    // R3: word extreme wraps
    run(1'b1, 1'b0, 1'b0, 8'h01, 256'd5, 256'h80008000, 256'h80008000);
    chk(result[31:0] == 32'h80000005, "R3 wrap", result, 256'h80000005);
    // R4: same sum saturates high
    run(1'b1, 1'b1, 1'b0, 8'h01, 256'd5, 256'h80008000, 256'h80008000);
    chk(result[31:0] == 32'h7FFFFFFF, "R4 sat high", result, 256'h7FFFFFFF);
    // R4: byte sum saturates low
    run(1'b0, 1'b1, 1'b0, 8'h01, 256'h80000000, 256'hFFFFFFFF, 256'h80808080);
    chk(result[31:0] == 32'h80000000, "R4 sat low", result, 256'h80000000);
    // R6: all lanes masked, merge
    s = {8{32'hCAFE0001}};
    run(1'b0, 1'b0, 1'b0, 8'h00, s, {8{32'h01010101}}, {8{32'h01010101}});
    chk(result == s, "R6 merge", result, s);
    // R7: all lanes masked, zeroing
    run(1'b1, 1'b0, 1'b1, 8'h00, s, {8{32'h01010101}}, {8{32'h01010101}});
    chk(result == '0, "R7 zero", result, '0);
    // R8: upper mask bits ignored in narrow form
    run(1'b0, 1'b0, 1'b1, 8'hF0, s, {8{32'h01010101}}, {8{32'h01010101}});
    chk(result_n == '0, "R8 upper mask ignored", result_n, '0);
    // R9: result holds and valid drops while idle
    held = result;
    repeat (3) @(negedge clk);
    chk(result == held, "R9 hold", result, held);
    chk(out_valid == 1'b0, "R9 valid drops", {255'd0, out_valid}, '0);
    // R10: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk(result == '0 && out_valid == 1'b0, "R10 reset clears", result, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule